// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Message Mailbox

This block lets two processors exchange 32-bit messages through one shared register map. Each processor, called the local side and the remote side, has its own register port with an address, a write enable, a read enable, write data and combinational read data, plus its own interrupt line. Eight channels each carry messages one way only. Each channel has a four-entry queue, and two shared control registers choose its direction.

The sender writes a channel's data register to queue a word. The receiver reads the same address to take the oldest word out. Each side has an interrupt status register and an enable register. A receive-pending bit cannot be cleared while its queue still holds data. Either side can read the other side's status, so a sender can poll the receiver's pending bit and treat the message as consumed once that bit drops.

Top module: `ipcMailbox`

## Requirements
- R1: A synchronous reset empties every queue and clears all direction, enable and status bits, so every register reads 0 and both interrupt lines are low.
- R2: Channel n's direction bits sit in the control word at byte address 4*(n/4): the receive bit at position 8*(n%4) and the transmit bit at position 4+8*(n%4). The local side is the writer when only the transmit bit is set. The remote side is the writer when only the receive bit is set. When both bits are set, or neither, the channel accepts no push and no pop and sets no status. Other control bits read as 0.
- R3: Data register addresses are 0x180+4n. A write from the writer side queues the 32-bit word. A read from the reader side returns the oldest queued word, and the read enable removes that word at the clock edge. Order is first in, first out.
- R4: Each queue holds 4 words, and a write to a full queue is dropped. Address 0x100+4n returns the full flag in bit 0. Address 0x140+4n returns the queued word count in bits [2:0].
- R5: Reading an empty data register returns 0 and removes nothing. Writes from the reader side leave the queue unchanged. Reads from the writer side return 0 and leave the queue unchanged.
- R6: A push and a pop on the same channel in the same cycle both take effect. Fullness and emptiness are judged on the state before the edge.
- R7: The local status register is at 0x70 and the remote one at 0x50. Bit 2n is receive-pending and bit 2n+1 is transmit-ready. At each edge where channel n's queue holds at least one word, the reader side's bit 2n becomes 1. At each edge where the queue is not full, the writer side's bit 2n+1 becomes 1. Status reads return the bits in [15:0].
- R8: Writing 1 to a status bit from either side clears it. The clear does not take effect if the bit's set condition holds in that same cycle. A pop in that cycle does not count: the queue is judged before it. Clears written by both sides in the same cycle combine by OR.
- R9: The local enable register is at 0x60 and the remote one at 0x40, using bits [15:0]. Each interrupt output is high exactly when its side's status ANDed with its side's enable is nonzero.
- R10: Read data shows the addressed register in the same cycle. Either side can read every register, including the other side's status and enable. Unmapped addresses and addresses whose two low bits are not 00 read 0 and have no effect.
- R11: When both sides write the same control or enable register in the same cycle, the local side's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| locAddr | input | 9 | Local side byte address |
| locWrEn | input | 1 | Local side write enable |
| locRdEn | input | 1 | Local side read enable (pops on data reads) |
| locWrData | input | 32 | Local side write data |
| locRdData | output | 32 | Local side read data, combinational |
| locIrq | output | 1 | Local side interrupt |
| remAddr | input | 9 | Remote side byte address |
| remWrEn | input | 1 | Remote side write enable |
| remRdEn | input | 1 | Remote side read enable (pops on data reads) |
| remWrData | input | 32 | Remote side write data |
| remRdData | output | 32 | Remote side read data, combinational |
| remIrq | output | 1 | Remote side interrupt |

## Verification
A queue pointer or count that goes wrong shows up in the next cycle's count or full readback, and a later data read then returns the wrong word. A status bit that is set or cleared wrongly changes the interrupt line in the cycle right after the edge, even if no side is reading status. A wrong direction decode shows up at once: a write that should land is dropped, or a read from the wrong side returns data. The reference model predicts both read ports and both interrupt lines in every cycle, so any such fault is caught within one cycle of reaching a port.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int CH_NUM     = 8;
  localparam int FIFO_DEPTH = 4;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 9;
  localparam int WA_W       = ADDR_W - 2;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int STAT_W     = 2 * CH_NUM;
  localparam int CTRL_REGS  = (CH_NUM + 3) / 4;

  // word-address map (byte address >> 2)
  localparam int WA_REM_EN = 'h10;
  localparam int WA_REM_ST = 'h14;
  localparam int WA_LOC_EN = 'h18;
  localparam int WA_LOC_ST = 'h1C;
  localparam int WA_FULL   = 'h40;
  localparam int WA_CNT    = 'h50;
  localparam int WA_DATA   = 'h60;

  typedef struct packed {
    logic [CH_NUM-1:0] push;
    logic [CH_NUM-1:0] pop;
    logic [CH_NUM-1:0] fromLoc;
  } mbxStrobe_t;
endpackage

// File: rtl/mbxFifo.sv
module mbxFifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic                           pop,
  input  logic [WIDTH-1:0]               wrData,
  output logic [WIDTH-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head = mem[rdPtr];
endmodule

// File: rtl/mbxData.sv
module mbxData
  import mbx_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  mbxStrobe_t                     stb,
  input  logic [WORD_W-1:0]              locWrData,
  input  logic [WORD_W-1:0]              remWrData,
  output logic [CH_NUM-1:0][WORD_W-1:0]  heads,
  output logic [CH_NUM-1:0][CNT_W-1:0]   counts
);
  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    logic [WORD_W-1:0] chWrData;
    assign chWrData = stb.fromLoc[n] ? locWrData : remWrData;

    mbxFifo #(
      .DEPTH (FIFO_DEPTH),
      .WIDTH (WORD_W)
    ) u_fifo (
      .clk    (clk),
      .rst    (rst),
      .push   (stb.push[n]),
      .pop    (stb.pop[n]),
      .wrData (chWrData),
      .head   (heads[n]),
      .count  (counts[n])
    );
  end
endmodule

// File: rtl/mbxCtrl.sv
module mbxCtrl
  import mbx_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              locAddr,
  input  logic                           locWrEn,
  input  logic                           locRdEn,
  input  logic [WORD_W-1:0]              locWrData,
  input  logic [ADDR_W-1:0]              remAddr,
  input  logic                           remWrEn,
  input  logic                           remRdEn,
  input  logic [WORD_W-1:0]              remWrData,
  input  logic [CH_NUM-1:0][WORD_W-1:0]  heads,
  input  logic [CH_NUM-1:0][CNT_W-1:0]   counts,
  output mbxStrobe_t                     stb,
  output logic [WORD_W-1:0]              locRdData,
  output logic [WORD_W-1:0]              remRdData,
  output logic [STAT_W-1:0]              locStat,
  output logic [STAT_W-1:0]              remStat,
  output logic [STAT_W-1:0]              locEn,
  output logic [STAT_W-1:0]              remEn,
  output logic [CH_NUM-1:0]              rxDir,
  output logic [CH_NUM-1:0]              txDir
);
  logic [WA_W-1:0]   locW, remW;
  logic [CH_NUM-1:0] locWrites, remWrites, notEmpty, isFull;
  logic [STAT_W-1:0] locSet, remSet, locClr, remClr;
  logic [CTRL_REGS-1:0][WORD_W-1:0] ctrlWord;
  logic [1:0][WA_W-1:0]   sideW;
  logic [1:0][CH_NUM-1:0] readsCh;
  logic [1:0][WORD_W-1:0] sideRd;

  // misaligned addresses map to an unused word
  assign locW = (locAddr[1:0] == 2'b00) ? locAddr[ADDR_W-1:2] : '1;
  assign remW = (remAddr[1:0] == 2'b00) ? remAddr[ADDR_W-1:2] : '1;

  always_comb begin
    for (int n = 0; n < CH_NUM; n++) begin
      locWrites[n] = txDir[n] & ~rxDir[n];
      remWrites[n] = rxDir[n] & ~txDir[n];
      notEmpty[n]  = counts[n] != '0;
      isFull[n]    = counts[n] == CNT_W'(FIFO_DEPTH);
    end
  end

  // queue strobes
  always_comb begin
    for (int n = 0; n < CH_NUM; n++) begin
      logic locHit, remHit;
      locHit = locW == WA_W'(WA_DATA + n);
      remHit = remW == WA_W'(WA_DATA + n);
      stb.push[n] = ~isFull[n] &
                    ((locWrEn & locHit & locWrites[n]) | (remWrEn & remHit & remWrites[n]));
      stb.pop[n]  = notEmpty[n] &
                    ((locRdEn & locHit & remWrites[n]) | (remRdEn & remHit & locWrites[n]));
      stb.fromLoc[n] = locWrites[n];
    end
  end

  // status set conditions and write-one-to-clear masks
  always_comb begin
    locSet = '0;
    remSet = '0;
    for (int n = 0; n < CH_NUM; n++) begin
      locSet[2*n]   = remWrites[n] & notEmpty[n];
      locSet[2*n+1] = locWrites[n] & ~isFull[n];
      remSet[2*n]   = locWrites[n] & notEmpty[n];
      remSet[2*n+1] = remWrites[n] & ~isFull[n];
    end
    locClr = ((locWrEn && locW == WA_W'(WA_LOC_ST)) ? locWrData[STAT_W-1:0] : '0) |
             ((remWrEn && remW == WA_W'(WA_LOC_ST)) ? remWrData[STAT_W-1:0] : '0);
    remClr = ((locWrEn && locW == WA_W'(WA_REM_ST)) ? locWrData[STAT_W-1:0] : '0) |
             ((remWrEn && remW == WA_W'(WA_REM_ST)) ? remWrData[STAT_W-1:0] : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locStat <= '0;
      remStat <= '0;
      locEn   <= '0;
      remEn   <= '0;
      rxDir   <= '0;
      txDir   <= '0;
    end else begin
      locStat <= locSet | (locStat & ~locClr);
      remStat <= remSet | (remStat & ~remClr);

      if (locWrEn && locW == WA_W'(WA_LOC_EN))      locEn <= locWrData[STAT_W-1:0];
      else if (remWrEn && remW == WA_W'(WA_LOC_EN)) locEn <= remWrData[STAT_W-1:0];

      if (locWrEn && locW == WA_W'(WA_REM_EN))      remEn <= locWrData[STAT_W-1:0];
      else if (remWrEn && remW == WA_W'(WA_REM_EN)) remEn <= remWrData[STAT_W-1:0];

      for (int n = 0; n < CH_NUM; n++) begin
        if (locWrEn && locW == WA_W'(n / 4)) begin
          rxDir[n] <= locWrData[8*(n%4)];
          txDir[n] <= locWrData[8*(n%4)+4];
        end else if (remWrEn && remW == WA_W'(n / 4)) begin
          rxDir[n] <= remWrData[8*(n%4)];
          txDir[n] <= remWrData[8*(n%4)+4];
        end
      end
    end
  end

  // readback
  always_comb begin
    ctrlWord = '0;
    for (int n = 0; n < CH_NUM; n++) begin
      ctrlWord[n/4][8*(n%4)]   = rxDir[n];
      ctrlWord[n/4][8*(n%4)+4] = txDir[n];
    end
  end

  assign sideW   = {remW, locW};
  assign readsCh = {locWrites, remWrites};

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      sideRd[s] = '0;
      for (int r = 0; r < CTRL_REGS; r++) begin
        if (sideW[s] == WA_W'(r)) sideRd[s] = ctrlWord[r];
      end
      if (sideW[s] == WA_W'(WA_REM_EN)) sideRd[s] = WORD_W'(remEn);
      if (sideW[s] == WA_W'(WA_REM_ST)) sideRd[s] = WORD_W'(remStat);
      if (sideW[s] == WA_W'(WA_LOC_EN)) sideRd[s] = WORD_W'(locEn);
      if (sideW[s] == WA_W'(WA_LOC_ST)) sideRd[s] = WORD_W'(locStat);
      for (int n = 0; n < CH_NUM; n++) begin
        if (sideW[s] == WA_W'(WA_FULL + n)) sideRd[s] = WORD_W'(isFull[n]);
        if (sideW[s] == WA_W'(WA_CNT + n))  sideRd[s] = WORD_W'(counts[n]);
        if (sideW[s] == WA_W'(WA_DATA + n) && readsCh[s][n] && notEmpty[n])
          sideRd[s] = heads[n];
      end
    end
  end

  assign locRdData = sideRd[0];
  assign remRdData = sideRd[1];
endmodule

// File: rtl/ipcMailbox.sv
module ipcMailbox
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic              locWrEn,
  input  logic              locRdEn,
  input  logic [WORD_W-1:0] locWrData,
  output logic [WORD_W-1:0] locRdData,
  output logic              locIrq,
  input  logic [ADDR_W-1:0] remAddr,
  input  logic              remWrEn,
  input  logic              remRdEn,
  input  logic [WORD_W-1:0] remWrData,
  output logic [WORD_W-1:0] remRdData,
  output logic              remIrq
);
  mbxStrobe_t                    stb;
  logic [CH_NUM-1:0][WORD_W-1:0] heads;
  logic [CH_NUM-1:0][CNT_W-1:0]  counts;
  logic [STAT_W-1:0]             locStat, remStat, locEn, remEn;
  logic [CH_NUM-1:0]             rxDir, txDir;

  mbxCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .locAddr   (locAddr),
    .locWrEn   (locWrEn),
    .locRdEn   (locRdEn),
    .locWrData (locWrData),
    .remAddr   (remAddr),
    .remWrEn   (remWrEn),
    .remRdEn   (remRdEn),
    .remWrData (remWrData),
    .heads     (heads),
    .counts    (counts),
    .stb       (stb),
    .locRdData (locRdData),
    .remRdData (remRdData),
    .locStat   (locStat),
    .remStat   (remStat),
    .locEn     (locEn),
    .remEn     (remEn),
    .rxDir     (rxDir),
    .txDir     (txDir)
  );

  mbxData u_data (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .locWrData (locWrData),
    .remWrData (remWrData),
    .heads     (heads),
    .counts    (counts)
  );

  assign locIrq = |(locStat & locEn);
  assign remIrq = |(remStat & remEn);
endmodule

// File: rtl/mbxChecker.sv
module mbxChecker
  import mbx_pkg::*;
(
  input logic                          clk,
  input logic                          rst,
  input mbxStrobe_t                    stb,
  input logic [CH_NUM-1:0][CNT_W-1:0]  counts,
  input logic [STAT_W-1:0]             locStat,
  input logic [STAT_W-1:0]             remStat,
  input logic [STAT_W-1:0]             locEn,
  input logic [STAT_W-1:0]             remEn,
  input logic                          locIrq,
  input logic                          remIrq,
  input logic [CH_NUM-1:0]             rxDir,
  input logic [CH_NUM-1:0]             txDir
);
  AST_LOC_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) locIrq |-> locEn != '0); // R9
  AST_REM_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) remIrq |-> remEn != '0); // R9

  for (genvar n = 0; n < CH_NUM; n++) begin : g_chk
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst) counts[n] <= CNT_W'(FIFO_DEPTH)); // R4
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst) stb.push[n] |-> counts[n] != CNT_W'(FIFO_DEPTH)); // R4
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst) stb.pop[n] |-> counts[n] != '0); // R5
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst) (rxDir[n] == txDir[n]) |-> !stb.push[n] && !stb.pop[n]); // R2
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst) stb.push[n] && !stb.pop[n] |=> counts[n] == $past(counts[n]) + CNT_W'(1)); // R3
    AST_BOTH_STEP: assert property (@(posedge clk) disable iff (rst) stb.push[n] && stb.pop[n] |=> $stable(counts[n])); // R6
    AST_RX_PEND_LOC: assert property (@(posedge clk) disable iff (rst) (rxDir[n] && !txDir[n] && counts[n] != '0) |=> locStat[2*n]); // R7
    AST_RX_PEND_REM: assert property (@(posedge clk) disable iff (rst) (txDir[n] && !rxDir[n] && counts[n] != '0) |=> remStat[2*n]); // R7
    AST_CLR_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst) $fell(locStat[2*n]) && $past(rxDir[n] && !txDir[n]) |-> $past(counts[n]) == '0); // R8
  end
endmodule

bind ipcMailbox mbxChecker u_chk (
  .clk     (clk),
  .rst     (rst),
  .stb     (stb),
  .counts  (counts),
  .locStat (locStat),
  .remStat (remStat),
  .locEn   (locEn),
  .remEn   (remEn),
  .locIrq  (locIrq),
  .remIrq  (remIrq),
  .rxDir   (rxDir),
  .txDir   (txDir)
);

// File: tb/ipcMailbox_tb.sv
module ipcMailbox_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [8:0]  lA, rA;
  logic        lW, lR, rW, rR;
  logic [31:0] lD, rD;
  logic [31:0] lQ, rQ;
  logic        lI, rI;

  ipcMailbox u_dut (
    .clk(clk), .rst(rst),
    .locAddr(lA), .locWrEn(lW), .locRdEn(lR), .locWrData(lD), .locRdData(lQ), .locIrq(lI),
    .remAddr(rA), .remWrEn(rW), .remRdEn(rR), .remWrData(rD), .remRdData(rQ), .remIrq(rI)
  );

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string scen  = "R1";

  // reference model
  logic [31:0] mq [8][$];
  bit          mRx [8] = '{default: 0};
  bit          mTx [8] = '{default: 0};
  logic [15:0] mLocEn = '0, mRemEn = '0, mLocSt = '0, mRemSt = '0;

  function automatic string tagOf(logic [8:0] a);
    if (a < 9'h008)                    return "R2";
    if (a == 9'h040 || a == 9'h060)    return "R9";
    if (a == 9'h050 || a == 9'h070)    return "R7";
    if (a >= 9'h100 && a < 9'h160)     return "R4";
    if (a >= 9'h180 && a < 9'h1A0)     return "R3";
    return "R10";
  endfunction

  function automatic logic [31:0] mRead(bit loc, logic [8:0] a);
    logic [31:0] r = '0;
    int n;
    if (a[1:0] != 2'b00) return '0;
    if (a < 9'h008) begin
      for (int k = 0; k < 4; k++) begin
        n = 4 * int'(a[8:2]) + k;
        r[8*k] = mRx[n];
        r[8*k+4] = mTx[n];
      end
      return r;
    end
    if (a == 9'h040) return {16'h0, mRemEn};
    if (a == 9'h050) return {16'h0, mRemSt};
    if (a == 9'h060) return {16'h0, mLocEn};
    if (a == 9'h070) return {16'h0, mLocSt};
    if (a >= 9'h100 && a < 9'h120) return (mq[(a-9'h100)/4].size() == 4) ? 32'd1 : 32'd0;
    if (a >= 9'h140 && a < 9'h160) return 32'(mq[(a-9'h140)/4].size());
    if (a >= 9'h180 && a < 9'h1A0) begin
      bit rdr;
      n = int'((a - 9'h180) / 4);
      rdr = loc ? (mRx[n] && !mTx[n]) : (mTx[n] && !mRx[n]);
      if (rdr && mq[n].size() > 0) return mq[n][0];
      return '0;
    end
    return '0;
  endfunction

  task automatic mStep();
    bit ne [8];
    bit fu [8];
    logic [15:0] lc, rc, ls, rs;
    if (rst) begin
      for (int n = 0; n < 8; n++) begin mq[n].delete(); mRx[n] = 0; mTx[n] = 0; end
      mLocEn = '0; mRemEn = '0; mLocSt = '0; mRemSt = '0;
      return;
    end
    for (int n = 0; n < 8; n++) begin ne[n] = mq[n].size() > 0; fu[n] = mq[n].size() == 4; end
    lc = ((lW && lA == 9'h070) ? lD[15:0] : 16'h0) | ((rW && rA == 9'h070) ? rD[15:0] : 16'h0);
    rc = ((lW && lA == 9'h050) ? lD[15:0] : 16'h0) | ((rW && rA == 9'h050) ? rD[15:0] : 16'h0);
    ls = '0; rs = '0;
    for (int n = 0; n < 8; n++) begin
      bit lwr = mTx[n] && !mRx[n];
      bit rwr = mRx[n] && !mTx[n];
      logic [8:0] da = 9'(9'h180 + 4*n);
      ls[2*n] = rwr && ne[n]; ls[2*n+1] = lwr && !fu[n];
      rs[2*n] = lwr && ne[n]; rs[2*n+1] = rwr && !fu[n];
      if (ne[n] && ((lR && lA == da && rwr) || (rR && rA == da && lwr))) void'(mq[n].pop_front());
      if (!fu[n] && lW && lA == da && lwr) mq[n].push_back(lD);
      else if (!fu[n] && rW && rA == da && rwr) mq[n].push_back(rD);
    end
    mLocSt = ls | (mLocSt & ~lc);
    mRemSt = rs | (mRemSt & ~rc);
    if (lW && lA == 9'h060) mLocEn = lD[15:0]; else if (rW && rA == 9'h060) mLocEn = rD[15:0];
    if (lW && lA == 9'h040) mRemEn = lD[15:0]; else if (rW && rA == 9'h040) mRemEn = rD[15:0];
    for (int n = 0; n < 8; n++) begin
      logic [8:0] ca = 9'(4 * (n / 4));
      if (lW && lA == ca) begin mRx[n] = lD[8*(n%4)]; mTx[n] = lD[8*(n%4)+4]; end
      else if (rW && rA == ca) begin mRx[n] = rD[8*(n%4)]; mTx[n] = rD[8*(n%4)+4]; end
    end
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s/%s act=%h exp=%h at %0t", tag, scen, act, exp, $time);
    end
  endtask

  task automatic cyc(logic [8:0] la, logic lwe, logic lre, logic [31:0] ld,
                     logic [8:0] ra, logic rwe, logic rre, logic [31:0] rd);
    lA = la; lW = lwe; lR = lre; lD = ld;
    rA = ra; rW = rwe; rR = rre; rD = rd;
    #1;
    chk(lQ, mRead(1, lA), tagOf(lA));
    chk(rQ, mRead(0, rA), tagOf(rA));
    chk(32'(lI), 32'(|(mLocSt & mLocEn)), "R9");
    chk(32'(rI), 32'(|(mRemSt & mRemEn)), "R9");
    mStep();
    @(negedge clk);
  endtask

  task automatic lwr(logic [8:0] a, logic [31:0] d); cyc(a, 1, 0, d, 9'h000, 0, 0, 0); endtask
  task automatic rwr(logic [8:0] a, logic [31:0] d); cyc(9'h004, 0, 0, 0, a, 1, 0, d); endtask
  task automatic lrd(logic [8:0] a); cyc(a, 0, 1, 0, 9'h070, 0, 0, 0); endtask
  task automatic rrd(logic [8:0] a); cyc(9'h050, 0, 0, 0, a, 0, 1, 0); endtask

  function automatic logic [8:0] pickAddr();
    int n = $urandom_range(0, 7);
    case ($urandom_range(0, 7))
      0, 1, 2: return 9'(9'h180 + 4*n);
      3:       return 9'(9'h140 + 4*n);
      4:       return 9'(9'h100 + 4*n);
      5:       return $urandom_range(0, 1) ? 9'h050 : 9'h070;
      6:       return $urandom_range(0, 1) ? 9'h040 : 9'h060;
      default: return 9'(4 * $urandom_range(0, 1));
    endcase
  endfunction

  initial begin
    rst = 1'b1;
    lA = '0; lW = 0; lR = 0; lD = '0; rA = '0; rW = 0; rR = 0; rD = '0;
    @(negedge clk);
    scen = "R1";
    repeat (2) cyc(9'h070, 0, 0, 0, 9'h050, 0, 0, 0);
    rst = 1'b0;
    for (int a = 0; a < 512; a += 4) cyc(9'(a), 0, 0, 0, 9'(a), 0, 1, 0);

    scen = "R2";
    lwr(9'h000, 32'h0011_0110);   // ch0 local writes, ch1 remote writes, ch2 both bits, ch3 off
    rwr(9'h004, 32'h1000_0110);   // ch4 local, ch5 remote, ch6 off, ch7 local
    cyc(9'h000, 0, 0, 0, 9'h004, 0, 0, 0);
    scen = "R9";
    lwr(9'h060, 32'h0000_FFFF);
    rwr(9'h040, 32'h0000_0001);
    cyc(9'h060, 0, 0, 0, 9'h040, 0, 0, 0);

    scen = "R3";
    lwr(9'h180, 32'h1111_1111);
    lwr(9'h180, 32'h2222_2222);
    cyc(9'h140, 0, 0, 0, 9'h050, 0, 0, 0);
    rrd(9'h180);
    cyc(9'h140, 0, 0, 0, 9'h180, 0, 0, 0);

    scen = "R4";
    for (int i = 0; i < 5; i++) lwr(9'h180, 32'hA000_0000 + i);
    cyc(9'h100, 0, 0, 0, 9'h140, 0, 0, 0);
    scen = "R6";
    cyc(9'h180, 1, 0, 32'hBEEF_0001, 9'h180, 0, 1, 0);
    cyc(9'h180, 1, 0, 32'hBEEF_0002, 9'h180, 0, 1, 0);
    cyc(9'h140, 0, 0, 0, 9'h100, 0, 0, 0);

    scen = "R5";
    lrd(9'h180);
    rwr(9'h180, 32'hDEAD_DEAD);
    rrd(9'h184);
    cyc(9'h140, 0, 0, 0, 9'h184, 0, 0, 0);

    scen = "R8";
    lwr(9'h050, 32'h0000_0001);
    cyc(9'h140, 0, 0, 0, 9'h050, 0, 0, 0);
    rrd(9'h180); rrd(9'h180);
    cyc(9'h050, 1, 0, 32'h1, 9'h180, 0, 1, 0);   // last pop with clear: clear ignored
    cyc(9'h050, 0, 0, 0, 9'h180, 0, 1, 0);       // empty read
    rwr(9'h050, 32'h0000_0001);
    cyc(9'h050, 0, 0, 0, 9'h050, 0, 0, 0);

    scen = "R7";
    rwr(9'h184, 32'h5555_0001);
    rwr(9'h184, 32'h5555_0002);
    cyc(9'h070, 0, 0, 0, 9'h070, 0, 0, 0);
    lrd(9'h184); lrd(9'h184);
    lwr(9'h070, 32'h0000_FFFF);
    cyc(9'h070, 0, 0, 0, 9'h050, 0, 0, 0);

    scen = "R2";
    lwr(9'h188, 32'h0BAD_0001);
    rwr(9'h188, 32'h0BAD_0002);
    cyc(9'h148, 0, 0, 0, 9'h18C, 1, 0, 32'h0BAD_0003);
    cyc(9'h14C, 0, 0, 0, 9'h148, 0, 0, 0);

    scen = "R11";
    cyc(9'h060, 1, 0, 32'h0000_00F0, 9'h060, 1, 0, 32'h0000_000F);
    cyc(9'h004, 1, 0, 32'h0000_0010, 9'h004, 1, 0, 32'h0000_0100);
    cyc(9'h004, 0, 0, 0, 9'h060, 0, 0, 0);
    cyc(9'h070, 1, 0, 32'h0000_0002, 9'h070, 1, 0, 32'h0000_0200);

    scen = "R10";
    cyc(9'h080, 0, 1, 0, 9'h1C0, 0, 1, 0);
    cyc(9'h181, 1, 1, 32'h1, 9'h071, 1, 0, 32'hFFFF);
    cyc(9'h050, 0, 0, 0, 9'h070, 0, 0, 0);
    cyc(9'h1FC, 0, 0, 0, 9'h060, 0, 0, 0);

    scen = "R3";
    lwr(9'h000, 32'h1001_1001);
    rwr(9'h004, 32'h0110_1001);
    lwr(9'h060, 32'h0000_5555);
    rwr(9'h040, 32'h0000_AAAA);
    for (int i = 0; i < 2500; i++) begin
      cyc(pickAddr(), $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, $urandom,
          pickAddr(), $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, $urandom);
    end

    scen = "R10";
    for (int a = 0; a < 512; a += 4) cyc(9'(a), 0, 0, 0, 9'(508 - a), 0, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule